// File: doc/BRIEF.md
# Byte-Register Multiply and Divide Unit

This block is an unsigned arithmetic helper on a byte-wide register bus. Software loads a multiplicand and writes a multiplier to get an 8x8 product, or loads a 16-bit dividend a byte at a time and writes a divisor to get a 16-bit quotient and a remainder. The operation is started by the write to the second operand itself; there is no separate start command.

The unit has two result registers. One is a 16-bit quotient. The other is a 16-bit register that holds either the last product or the last remainder, whichever operation finished most recently. Both are read a byte at a time through a combinational read port. Multiplies run on an iterative shift-add engine and divides on an iterative restoring shift-subtract engine. While either engine runs, `busy` is high. A divide by zero does not start the engine and completes on the next clock edge with a fixed result.

Top module: `mulDivUnit`

## Requirements
- R1: After reset, `busy` is 0 and all four result bytes read as 0x00.
- R2: The multiplicand is written at write address 0. It keeps its value across any number of multiplies until address 0 is written again.
- R3: A write to address 1 starts an unsigned multiply of the stored multiplicand by the written byte. `busy` is high for exactly 8 cycles after the write edge. The 16-bit product appears in the shared result register at the edge where `busy` falls.
- R4: The dividend is loaded as two separate bytes: the low byte at write address 2 and the high byte at write address 3.
- R5: A write of a nonzero byte to address 4 starts an unsigned 16/8 divide. `busy` is high for exactly 16 cycles. When `busy` falls, the quotient register and the shared result register update together. The remainder overwrites any earlier product.
- R6: A write of 0x00 to address 4 sets the quotient to 0xFFFF and the shared result register to the stored dividend on that same edge. `busy` stays low.
- R7: A trigger write (address 1, or address 4) that arrives while `busy` is high abandons the running operation and restarts with the new operands. The abandoned operation never writes a result.
- R8: While an operation is running, both result registers keep their previous values.
- R9: Writes to addresses 5, 6 and 7 change neither the result registers nor `busy`.
- R10: The read port selects a byte with `rdSel`: 0 is the quotient low byte, 1 is the quotient high byte, 2 is the shared result low byte, and 3 is the shared result high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Write register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data byte |
| rdSel | input | 2 | Read byte select |
| rdData | output | 8 | Selected result byte |
| busy | output | 1 | An iterative operation is in progress |

## Verification
The bench aims at four corner cases.

- **Divide by zero.** A design that ran the engine, or returned zeros, would show a raised `busy` or the wrong fixed pattern.
- **Retriggering mid-run.** This covers a multiply overtaken by a divide, a divide overtaken by a divide, and a divide cancelled by a divide by zero. A design that let the stale operation finish would commit a result that the reference never produces.
- **Off-by-one iteration counts.** These show up as `busy` falling a cycle early or late, or as a product or quotient that is shifted by one place.
- **The shared register and held operands.** Back-to-back multiplies with one multiplicand, and a remainder landing over a product, catch designs that clear operands or keep separate product and remainder storage.

// File: rtl/mulDivPkg.sv
package mulDivPkg;
  localparam int SEL_W = 3;
  localparam int RD_W  = 2;

  localparam logic [SEL_W-1:0] WA_MCAND  = 3'd0;
  localparam logic [SEL_W-1:0] WA_MPLIER = 3'd1;
  localparam logic [SEL_W-1:0] WA_DVD_LO = 3'd2;
  localparam logic [SEL_W-1:0] WA_DVD_HI = 3'd3;
  localparam logic [SEL_W-1:0] WA_DIVSR  = 3'd4;

  typedef struct packed {
    logic wrMcand;
    logic wrDvdLo;
    logic wrDvdHi;
    logic startMul;
    logic startDiv;
    logic divZero;
    logic stepMul;
    logic stepDiv;
    logic lastStep;
  } mdCtl_t;
endpackage

// File: rtl/mulDivCtrl.sv
module mulDivCtrl
  import mulDivPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [OPW-1:0]   wrData,
  output mdCtl_t           ctl,
  output logic             busy
);
  localparam int MUL_STEPS = OPW;
  localparam int DIV_STEPS = 2 * OPW;
  localparam int CNT_W     = $clog2(DIV_STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV} mdState_t;

  mdState_t   state;
  logic [CNT_W-1:0] cnt;
  logic       trigger;

  always_comb begin
    ctl          = '0;
    ctl.wrMcand  = wrEn && regSel == WA_MCAND;
    ctl.wrDvdLo  = wrEn && regSel == WA_DVD_LO;
    ctl.wrDvdHi  = wrEn && regSel == WA_DVD_HI;
    ctl.startMul = wrEn && regSel == WA_MPLIER;
    ctl.startDiv = wrEn && regSel == WA_DIVSR && wrData != '0;
    ctl.divZero  = wrEn && regSel == WA_DIVSR && wrData == '0;
    trigger      = ctl.startMul || ctl.startDiv || ctl.divZero;
    ctl.stepMul  = state == S_MUL && !trigger;
    ctl.stepDiv  = state == S_DIV && !trigger;
    ctl.lastStep = cnt == CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (ctl.startMul) begin
      state <= S_MUL;
      cnt   <= CNT_W'(MUL_STEPS);
    end else if (ctl.startDiv) begin
      state <= S_DIV;
      cnt   <= CNT_W'(DIV_STEPS);
    end else if (ctl.divZero) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (state != S_IDLE) begin
      cnt <= cnt - CNT_W'(1);
      if (ctl.lastStep) state <= S_IDLE;
    end
  end

  assign busy = state != S_IDLE;
endmodule

// File: rtl/mulDivPath.sv
module mulDivPath
  import mulDivPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdCtl_t           ctl,
  input  logic [OPW-1:0]   wrData,
  output logic [2*OPW-1:0] quoOut,
  output logic [2*OPW-1:0] resOut,
  output logic [2*OPW-1:0] dvdOut
);
  localparam int RES_W = 2 * OPW;

  logic [OPW-1:0]   mcandReg;
  logic [RES_W-1:0] dvdReg;
  logic [RES_W-1:0] accReg;
  logic [RES_W-1:0] shiftA;
  logic [OPW-1:0]   shiftB;
  logic [OPW-1:0]   remWork;
  logic [RES_W-1:0] quoReg;
  logic [RES_W-1:0] resReg;

  logic [RES_W-1:0] accNext;
  logic [OPW:0]     trial;
  logic [OPW:0]     diff;
  logic             fits;
  logic [OPW-1:0]   remNext;
  logic [RES_W-1:0] quoNext;

  always_comb begin
    accNext = accReg + (shiftB[0] ? shiftA : '0);
    trial   = {remWork, shiftA[RES_W-1]};
    diff    = trial - {1'b0, shiftB};
    fits    = !diff[OPW];
    remNext = fits ? diff[OPW-1:0] : trial[OPW-1:0];
    quoNext = {shiftA[RES_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg <= '0;
      dvdReg   <= '0;
      accReg   <= '0;
      shiftA   <= '0;
      shiftB   <= '0;
      remWork  <= '0;
      quoReg   <= '0;
      resReg   <= '0;
    end else begin
      if (ctl.wrMcand) mcandReg <= wrData;
      if (ctl.wrDvdLo) dvdReg[OPW-1:0] <= wrData;
      if (ctl.wrDvdHi) dvdReg[RES_W-1:OPW] <= wrData;
      if (ctl.startMul) begin
        accReg <= '0;
        shiftA <= {{OPW{1'b0}}, mcandReg};
        shiftB <= wrData;
      end else if (ctl.startDiv) begin
        remWork <= '0;
        shiftA  <= dvdReg;
        shiftB  <= wrData;
      end else if (ctl.divZero) begin
        quoReg <= '1;
        resReg <= dvdReg;
      end else if (ctl.stepMul) begin
        accReg <= accNext;
        shiftA <= shiftA << 1;
        shiftB <= shiftB >> 1;
        if (ctl.lastStep) resReg <= accNext;
      end else if (ctl.stepDiv) begin
        remWork <= remNext;
        shiftA  <= quoNext;
        if (ctl.lastStep) begin
          quoReg <= quoNext;
          resReg <= {{OPW{1'b0}}, remNext};
        end
      end
    end
  end

  assign quoOut = quoReg;
  assign resOut = resReg;
  assign dvdOut = dvdReg;
endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mulDivPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic [OPW-1:0]   wrData,
  input  logic [RD_W-1:0]  rdSel,
  output logic [OPW-1:0]   rdData,
  output logic             busy
);
  localparam int RES_W = 2 * OPW;

  mdCtl_t           ctl;
  logic [RES_W-1:0] quoVal;
  logic [RES_W-1:0] resVal;
  logic [RES_W-1:0] dvdVal;

  mulDivCtrl #(.OPW(OPW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .ctl(ctl), .busy(busy)
  );

  mulDivPath #(.OPW(OPW)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .quoOut(quoVal), .resOut(resVal), .dvdOut(dvdVal)
  );

  always_comb begin
    case (rdSel)
      2'd0:    rdData = quoVal[OPW-1:0];
      2'd1:    rdData = quoVal[RES_W-1:OPW];
      2'd2:    rdData = resVal[OPW-1:0];
      default: rdData = resVal[RES_W-1:OPW];
    endcase
  end
endmodule

// File: rtl/mulDivChk.sv
module mulDivChk
  import mulDivPkg::*;
#(
  parameter int OPW = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] regSel,
  input logic             wrEn,
  input logic [OPW-1:0]   wrData,
  input logic             busy,
  input logic [2*OPW-1:0] quoVal,
  input logic [2*OPW-1:0] resVal,
  input logic [2*OPW-1:0] dvdVal
);
  p_dbz_no_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == WA_DIVSR && wrData == '0) |=> !busy);

  p_dbz_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == WA_DIVSR && wrData == '0) |=> (quoVal == '1 && resVal == $past(dvdVal)));

  p_mul_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == WA_MPLIER) |=> busy);

  p_div_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == WA_DIVSR && wrData != '0) |=> busy);

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(quoVal) && $stable(resVal)));

  p_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel > WA_DIVSR && !busy) |=> ($stable(quoVal) && $stable(resVal) && !busy));
endmodule

bind mulDivUnit mulDivChk #(.OPW(OPW)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .busy(busy), .quoVal(quoVal), .resVal(resVal), .dvdVal(dvdVal)
);

// File: tb/mulDivUnit_bench.sv
`timescale 1ns/1ps
module mulDivUnit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [7:0] rdData;
  logic       busy;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference state
  int mcandM = 0, dvdM = 0, quoM = 0, resM = 0;
  int kindM = 0, cntM = 0, pendQ = 0, pendR = 0;
  logic [7:0] obs [4];

  always #2.5 clk = ~clk;

  mulDivUnit u_mulDivUnit (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .busy(busy)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mcandM = 0; dvdM = 0; quoM = 0; resM = 0; kindM = 0; cntM = 0;
    end else if (wrEn && regSel == 3'd1) begin
      pendR = mcandM * int'(wrData); kindM = 1; cntM = 8;
    end else if (wrEn && regSel == 3'd4) begin
      if (wrData == 0) begin
        quoM = 16'hFFFF; resM = dvdM; kindM = 0; cntM = 0;
      end else begin
        pendQ = dvdM / int'(wrData); pendR = dvdM % int'(wrData);
        kindM = 2; cntM = 16;
      end
    end else begin
      if (wrEn && regSel == 3'd0) mcandM = int'(wrData);
      if (wrEn && regSel == 3'd2) dvdM = (dvdM & 16'hFF00) | int'(wrData);
      if (wrEn && regSel == 3'd3) dvdM = (dvdM & 16'h00FF) | (int'(wrData) << 8);
      if (kindM != 0) begin
        cntM = cntM - 1;
        if (cntM == 0) begin
          if (kindM == 2) quoM = pendQ;
          resM = pendR;
          kindM = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, int'(busy), int'(kindM != 0), "busy");
      for (int s = 0; s < 4; s++) begin
        int expB;
        rdSel = 2'(s);
        #0.1;
        obs[s] = rdData;
        case (s)
          0: expB = quoM & 8'hFF;
          1: expB = (quoM >> 8) & 8'hFF;
          2: expB = resM & 8'hFF;
          default: expB = (resM >> 8) & 8'hFF;
        endcase
        check(curReq, int'(rdData), expB, $sformatf("rdSel=%0d", s));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel <= a; wrData <= d; wrEn <= 1'b1;
    @(negedge clk);
    wrEn <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // directed check with hand-computed values; R10 byte mapping
  task automatic chkRes(input int q, input int r, input string req);
    @(negedge clk);
    #1;
    check(req, {obs[1], obs[0]}, q, "R10 quotient bytes");
    check(req, {obs[3], obs[2]}, r, "R10 result bytes");
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired expected=finish actual=timeout");
    summary();
  end

  initial begin
    curReq = "R1";
    idle(4);
    rstN = 1'b1;
    idle(2);
    chkRes(0, 0, "R1");

    curReq = "R3";
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    idle(9);
    chkRes(0, 16'h03A8, "R3");
    curReq = "R2";
    wr(3'd1, 8'h02);
    idle(9);
    chkRes(0, 16'h0024, "R2");
    curReq = "R3";
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    idle(9);
    chkRes(0, 16'hFE01, "R3");

    curReq = "R4";
    wr(3'd2, 8'hE8);
    wr(3'd3, 8'h03);
    curReq = "R5";
    wr(3'd4, 8'h07);
    idle(17);
    chkRes(16'h008E, 16'h0006, "R5");
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'h01);
    idle(17);
    chkRes(16'hFFFF, 0, "R5");

    curReq = "R6";
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd4, 8'h00);
    chkRes(16'hFFFF, 16'h1234, "R6");

    curReq = "R7";
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h10);
    idle(3);
    wr(3'd4, 8'h05);
    idle(17);
    chkRes(16'h1234 / 5, 16'h1234 % 5, "R7");
    wr(3'd4, 8'h03);
    idle(5);
    wr(3'd4, 8'h09);
    idle(17);
    chkRes(16'h1234 / 9, 16'h1234 % 9, "R7");
    wr(3'd4, 8'h03);
    idle(6);
    wr(3'd4, 8'h00);
    chkRes(16'hFFFF, 16'h1234, "R7");
    wr(3'd1, 8'h03);
    idle(7);
    wr(3'd1, 8'h04);
    idle(9);
    chkRes(16'hFFFF, 16'h0040, "R7");

    curReq = "R8";
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h77);
    idle(10);
    chkRes(16'hFFFF, 16'h0050, "R8");

    curReq = "R9";
    wr(3'd5, 8'hAA);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h55);
    chkRes(16'hFFFF, 16'h0050, "R9");

    curReq = "R5";
    for (int i = 0; i < 60; i++) begin
      int op = $urandom_range(0, 5);
      wr(3'(op), 8'($urandom_range(0, 255)));
      idle($urandom_range(0, 18));
    end
    idle(20);
    summary();
  end
endmodule